// File: doc/BRIEF.md
# Short-Vector Register Index Sequencer

This block turns a single vector floating-point operation into a run of per-element register index triples. When a start pulse is accepted, it captures a destination index, two source indices, a length field, a stride field and a scalar-only flag. On each following cycle it presents one element: a destination index, a first-source index and a second-source index, with a valid strobe and a marker on the final element. The arithmetic datapath that consumes these triples sends back a set of exception flags for each element. The sequencer ORs them together and reports the combined set once every element has answered.

Each 5-bit index is made of a bank (the upper two bits) and a position within an eight-register bank (the lower three bits). Stepping changes only the position, which wraps modulo eight. When the destination sits in bank 0 the operation is treated as scalar. A second source in bank 0 is a scalar operand that stays the same for every element. If the operation code is undefined, the sequence is abandoned at once and an invalid-operation pulse is raised in place of any elements.

Top module: `vec_idx_seq`

## Requirements
- R1: The per-element step is 2 when both bits of `stride_i` are 1, and 1 for the values 00, 01 and 10.
- R2: The number of elements is `len_i`+1 (1 to 8). It is forced to 1 when `scalar_i` is 1 or when the destination bank `dst_i[4:3]` is 00.
- R3: For each index, bits 4:3 (the bank) never change within a sequence. After each element, bits 2:0 of the destination and the first source advance by the step, modulo 8.
- R4: The second source advances the same way only when its bank `srcb_i[4:3]` is nonzero. When that bank is 00, the same index is repeated on every element.
- R5: Element k (counting from 0) is presented with `elem_vld_o`=1 in the (k+1)-th cycle after the cycle in which start was sampled. Elements appear on consecutive cycles. `last_o` is 1 only on the final element.
- R6: An accepted start with `op_undef_i`=1 produces no elements and no `done_o`. Instead, `undef_o` is high for exactly the one cycle after the start.
- R7: `busy_o` is 1 exactly in the cycles that present an element. A start that arrives while elements are being issued, or while flags are still outstanding, is ignored.
- R8: The flags from every element are ORed together, and a set flag does not stop the sequence. `done_o` pulses for one cycle in the cycle after the final element's `flag_vld_i` is sampled, and `flags_o` then holds the OR. `flag_vld_i` is ignored when no flags are outstanding.
- R9: After reset, `elem_vld_o`, `last_o`, `busy_o`, `done_o`, `undef_o` and `flags_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request for one operation |
| dst_i | input | 5 | Destination register index |
| srca_i | input | 5 | First-source register index |
| srcb_i | input | 5 | Second-source register index |
| len_i | input | 3 | Length field: element count minus one |
| stride_i | input | 2 | Stride control field |
| scalar_i | input | 1 | Operation is scalar-only |
| op_undef_i | input | 1 | Operation code is undefined |
| flag_vld_i | input | 1 | Datapath returns one element's flags |
| flag_i | input | 5 | Exception flags of that element |
| elem_vld_o | output | 1 | An element triple is presented |
| dst_o | output | 5 | Destination index of the element |
| srca_o | output | 5 | First-source index of the element |
| srcb_o | output | 5 | Second-source index of the element |
| last_o | output | 1 | Final element of the sequence |
| busy_o | output | 1 | Elements are being issued |
| done_o | output | 1 | Pulse: combined flags are ready |
| flags_o | output | 5 | OR of all element flags |
| undef_o | output | 1 | Pulse: undefined operation rejected |

## Verification
A position counter that has lost sync shows up on the very next element. The index leaves its bank, or it steps by a wrong amount, and the bench compares every triple in every cycle. An error in the remaining-element count shows up as a missing or extra `elem_vld_o` cycle, or as `last_o` on the wrong element. Faults in the flag accumulator show up only at the end of the sequence: `done_o` fires a cycle early or late, or `flags_o` carries a bit that no element returned. Flags are therefore returned both alongside the elements and after long gaps, and stray strobes and starts are injected while the block is idle or busy.

// File: rtl/vis_pkg.sv
package vis_pkg;
    localparam int unsigned VIS_IDX_W  = 5;
    localparam int unsigned VIS_LOW_W  = 3;
    localparam int unsigned VIS_LEN_W  = 3;
    localparam int unsigned VIS_FLAG_W = 5;

    // step amount encoded by the two-bit stride field
    function automatic int unsigned vis_step_of(input logic [1:0] fld);
        return (fld == 2'b11) ? 2 : 1;
    endfunction
endpackage

// File: rtl/vis_idx_step.sv
module vis_idx_step #(
    parameter int unsigned IDX_W = 5,
    parameter int unsigned LOW_W = 3
) (
    input  logic [IDX_W-1:0] idx_i,
    input  logic [LOW_W-1:0] step_i,
    input  logic             hold_i,
    output logic [IDX_W-1:0] idx_o
);
    logic [LOW_W-1:0] low_nxt;

    assign low_nxt = idx_i[LOW_W-1:0] + step_i;
    assign idx_o   = hold_i ? idx_i : {idx_i[IDX_W-1:LOW_W], low_nxt};
endmodule

// File: rtl/vis_flag_acc.sv
module vis_flag_acc #(
    parameter int unsigned FLAG_W = 5,
    parameter int unsigned CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_i,
    input  logic [CNT_W-1:0]  need_i,
    input  logic              flag_vld_i,
    input  logic [FLAG_W-1:0] flag_i,
    output logic              pending_o,
    output logic              done_o,
    output logic [FLAG_W-1:0] flags_o
);
    typedef struct packed {
        logic              pending;
        logic [CNT_W-1:0]  got;
        logic [CNT_W-1:0]  need;
        logic [FLAG_W-1:0] acc;
        logic              done;
        logic [FLAG_W-1:0] res;
    } acc_t;

    acc_t a_d, a_q;

    always_comb begin
        a_d      = a_q;
        a_d.done = 1'b0;
        if (arm_i) begin
            a_d.pending = 1'b1;
            a_d.got     = '0;
            a_d.need    = need_i;
            a_d.acc     = '0;
        end else if (a_q.pending && flag_vld_i) begin
            if (a_q.got + 1'b1 == a_q.need) begin
                a_d.pending = 1'b0;
                a_d.done    = 1'b1;
                a_d.res     = a_q.acc | flag_i;
            end else begin
                a_d.got = a_q.got + 1'b1;
                a_d.acc = a_q.acc | flag_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end

    assign pending_o = a_q.pending;
    assign done_o    = a_q.done;
    assign flags_o   = a_q.res;
endmodule

// File: rtl/vec_idx_seq.sv
module vec_idx_seq #(
    parameter int unsigned IDX_W  = vis_pkg::VIS_IDX_W,
    parameter int unsigned LOW_W  = vis_pkg::VIS_LOW_W,
    parameter int unsigned LEN_W  = vis_pkg::VIS_LEN_W,
    parameter int unsigned FLAG_W = vis_pkg::VIS_FLAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [IDX_W-1:0]  dst_i,
    input  logic [IDX_W-1:0]  srca_i,
    input  logic [IDX_W-1:0]  srcb_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [1:0]        stride_i,
    input  logic              scalar_i,
    input  logic              op_undef_i,
    input  logic              flag_vld_i,
    input  logic [FLAG_W-1:0] flag_i,
    output logic              elem_vld_o,
    output logic [IDX_W-1:0]  dst_o,
    output logic [IDX_W-1:0]  srca_o,
    output logic [IDX_W-1:0]  srcb_o,
    output logic              last_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [FLAG_W-1:0] flags_o,
    output logic              undef_o
);
    localparam int unsigned CNT_W  = LEN_W + 1;
    localparam int unsigned BANK_W = IDX_W - LOW_W;
    localparam int unsigned N_IDX  = 3;

    typedef struct packed {
        logic             issuing;
        logic [IDX_W-1:0] dst;
        logic [IDX_W-1:0] sa;
        logic [IDX_W-1:0] sb;
        logic             sb_hold;
        logic [LOW_W-1:0] step;
        logic [CNT_W-1:0] remain;
        logic             undef;
    } seq_t;

    seq_t s_d, s_q;

    logic [N_IDX-1:0][IDX_W-1:0] cur_idx, nxt_idx;
    logic [N_IDX-1:0]            hold;
    logic                        acc_pending;
    logic                        accept;
    logic                        arm;
    logic [CNT_W-1:0]            cnt_new;
    logic [LOW_W-1:0]            step_new;

    assign cur_idx = {s_q.sb, s_q.sa, s_q.dst};
    assign hold    = {s_q.sb_hold, 1'b0, 1'b0};

    for (genvar g = 0; g < N_IDX; g++) begin : g_step
        vis_idx_step #(.IDX_W(IDX_W), .LOW_W(LOW_W)) i_step (
            .idx_i  (cur_idx[g]),
            .step_i (s_q.step),
            .hold_i (hold[g]),
            .idx_o  (nxt_idx[g])
        );
    end

    assign accept   = start_i && !s_q.issuing && !acc_pending;
    assign arm      = accept && !op_undef_i;
    assign step_new = LOW_W'(vis_pkg::vis_step_of(stride_i));
    assign cnt_new  = (scalar_i || dst_i[IDX_W-1:LOW_W] == BANK_W'(0))
                      ? CNT_W'(1) : ({1'b0, len_i} + CNT_W'(1));

    always_comb begin
        s_d       = s_q;
        s_d.undef = 1'b0;
        if (s_q.issuing) begin
            if (s_q.remain == CNT_W'(1)) begin
                s_d.issuing = 1'b0;
            end else begin
                s_d.dst    = nxt_idx[0];
                s_d.sa     = nxt_idx[1];
                s_d.sb     = nxt_idx[2];
                s_d.remain = s_q.remain - 1'b1;
            end
        end
        if (accept) begin
            if (op_undef_i) begin
                s_d.undef = 1'b1;
            end else begin
                s_d.issuing = 1'b1;
                s_d.dst     = dst_i;
                s_d.sa      = srca_i;
                s_d.sb      = srcb_i;
                s_d.sb_hold = (srcb_i[IDX_W-1:LOW_W] == BANK_W'(0));
                s_d.step    = step_new;
                s_d.remain  = cnt_new;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    vis_flag_acc #(.FLAG_W(FLAG_W), .CNT_W(CNT_W)) i_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm_i      (arm),
        .need_i     (cnt_new),
        .flag_vld_i (flag_vld_i),
        .flag_i     (flag_i),
        .pending_o  (acc_pending),
        .done_o     (done_o),
        .flags_o    (flags_o)
    );

    assign elem_vld_o = s_q.issuing;
    assign busy_o     = s_q.issuing;
    assign dst_o      = s_q.dst;
    assign srca_o     = s_q.sa;
    assign srcb_o     = s_q.sb;
    assign last_o     = s_q.issuing && (s_q.remain == CNT_W'(1));
    assign undef_o    = s_q.undef;
endmodule

// File: rtl/vec_idx_seq_chk.sv
module vec_idx_seq_chk #(
    parameter int unsigned IDX_W = 5,
    parameter int unsigned LOW_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             elem_vld_o,
    input logic [IDX_W-1:0] dst_o,
    input logic [IDX_W-1:0] srca_o,
    input logic [IDX_W-1:0] srcb_o,
    input logic             last_o,
    input logic             busy_o,
    input logic             done_o,
    input logic             undef_o
);
    logic             prv_vld, prv_last;
    logic [IDX_W-1:0] prv_dst, prv_sa, prv_sb;
    logic [LOW_W-1:0] dst_dif;
    logic             cont;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prv_vld  <= 1'b0;
            prv_last <= 1'b0;
            prv_dst  <= '0;
            prv_sa   <= '0;
            prv_sb   <= '0;
        end else begin
            prv_vld  <= elem_vld_o;
            prv_last <= last_o;
            prv_dst  <= dst_o;
            prv_sa   <= srca_o;
            prv_sb   <= srcb_o;
        end
    end

    assign cont    = elem_vld_o && prv_vld && !prv_last;
    assign dst_dif = dst_o[LOW_W-1:0] - prv_dst[LOW_W-1:0];

    AST_LAST_IN_ELEM: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> elem_vld_o); // R5
    AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_vld_o && !last_o) |=> elem_vld_o); // R5
    AST_STEP_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        cont |-> (dst_dif == LOW_W'(1) || dst_dif == LOW_W'(2))); // R1
    AST_BANK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        cont |-> (dst_o[IDX_W-1:LOW_W] == prv_dst[IDX_W-1:LOW_W]
                  && srca_o[IDX_W-1:LOW_W] == prv_sa[IDX_W-1:LOW_W])); // R3
    AST_SRCB_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (cont && prv_sb[IDX_W-1:LOW_W] == '0) |-> srcb_o == prv_sb); // R4
    AST_BUSY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o == elem_vld_o); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8
    AST_UNDEF_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        undef_o |-> (!elem_vld_o && !done_o)); // R6
endmodule

bind vec_idx_seq vec_idx_seq_chk #(.IDX_W(IDX_W), .LOW_W(LOW_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .elem_vld_o (elem_vld_o),
    .dst_o      (dst_o),
    .srca_o     (srca_o),
    .srcb_o     (srcb_o),
    .last_o     (last_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .undef_o    (undef_o)
);

// File: tb/test_vec_idx_seq.sv
module test_vec_idx_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [4:0] dst_i = '0, srca_i = '0, srcb_i = '0;
    logic [2:0] len_i = '0;
    logic [1:0] stride_i = '0;
    logic       scalar_i = 1'b0, op_undef_i = 1'b0;
    logic       flag_vld_i = 1'b0;
    logic [4:0] flag_i = '0;
    logic       elem_vld_o, last_o, busy_o, done_o, undef_o;
    logic [4:0] dst_o, srca_o, srcb_o, flags_o;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    vec_idx_seq i_vec_idx_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .dst_i(dst_i),
        .srca_i(srca_i), .srcb_i(srcb_i), .len_i(len_i), .stride_i(stride_i),
        .scalar_i(scalar_i), .op_undef_i(op_undef_i), .flag_vld_i(flag_vld_i),
        .flag_i(flag_i), .elem_vld_o(elem_vld_o), .dst_o(dst_o),
        .srca_o(srca_o), .srcb_o(srcb_o), .last_o(last_o), .busy_o(busy_o),
        .done_o(done_o), .flags_o(flags_o), .undef_o(undef_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] adv(input logic [4:0] idx, input int st);
        logic [2:0] lo;
        lo = idx[2:0] + 3'(st);
        return {idx[4:3], lo};
    endfunction

    function automatic int exp_cnt(input logic [4:0] d, input logic [2:0] l, input logic sc);
        return (sc || d[4:3] == 2'b00) ? 1 : int'(l) + 1;
    endfunction

    // late = 0: flags return with each element; late = 1: after issue, with gaps
    task automatic run_seq(input logic [4:0] d, input logic [4:0] a, input logic [4:0] b,
                           input logic [2:0] l, input logic [1:0] s, input logic sc,
                           input bit late, input bit zero_flags);
        int n, st;
        logic [4:0] ed, ea, eb, orv;
        logic [4:0] fl [8];
        n  = exp_cnt(d, l, sc);
        st = (s == 2'b11) ? 2 : 1;
        ed = d; ea = a; eb = b; orv = '0;
        for (int i = 0; i < 8; i++) begin
            fl[i] = zero_flags ? 5'd0 : 5'($urandom_range(0, 31) & ((i % 3 == 0) ? 31 : 0));
        end
        @(negedge clk);
        start_i = 1'b1; op_undef_i = 1'b0;
        dst_i = d; srca_i = a; srcb_i = b; len_i = l; stride_i = s; scalar_i = sc;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < n; i++) begin
            chk("R5 elem_vld", elem_vld_o, 1);
            chk("R7 busy", busy_o, 1);
            chk("R3 dst", dst_o, ed);
            chk("R3 srca", srca_o, ea);
            chk("R4 srcb", srcb_o, eb);
            chk("R5 last", last_o, (i == n - 1));
            if (i == 0) begin
                // R7: stray start while issuing
                start_i = 1'b1; dst_i = ~d; srca_i = ~a; len_i = 3'd7;
            end else begin
                start_i = 1'b0;
            end
            if (!late) begin
                flag_vld_i = 1'b1; flag_i = fl[i]; orv |= fl[i];
            end
            ed = adv(ed, st);
            ea = adv(ea, st);
            if (b[4:3] != 2'b00) eb = adv(eb, st);
            @(negedge clk);
            flag_vld_i = 1'b0; start_i = 1'b0;
        end
        chk("R5 no extra elem", elem_vld_o, 0);
        chk("R7 busy low", busy_o, 0);
        if (late) begin
            for (int i = 0; i < n; i++) begin
                chk("R8 no early done", done_o, 0);
                // R7: stray start while flags outstanding
                start_i = (i == 0);
                @(negedge clk);
                start_i = 1'b0;
                chk("R7 start ignored when pending", elem_vld_o, 0);
                flag_vld_i = 1'b1; flag_i = fl[i]; orv |= fl[i];
                @(negedge clk);
                flag_vld_i = 1'b0;
            end
        end
        chk("R8 done", done_o, 1);
        chk("R8 flags", flags_o, orv);
        @(negedge clk);
        chk("R8 done one cycle", done_o, 0);
        chk("R7 no restart", elem_vld_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R9 elem_vld", elem_vld_o, 0);
        chk("R9 busy", busy_o, 0);
        chk("R9 done", done_o, 0);
        chk("R9 undef", undef_o, 0);
        chk("R9 flags", flags_o, 0);
        chk("R9 last", last_o, 0);
        rst_n = 1'b1;
        void'($urandom(32'd1234));

        // R8: stray flags while idle must not reach the next result
        @(negedge clk);
        flag_vld_i = 1'b1; flag_i = 5'h1f;
        @(negedge clk);
        flag_vld_i = 1'b0;
        chk("R8 idle flag ignored", done_o, 0);
        run_seq(5'b01_110, 5'b10_111, 5'b11_001, 3'd3, 2'b00, 1'b0, 1'b0, 1'b1);

        // R1 stride 2 wrapping, R4 srcb fixed in bank 0
        run_seq(5'b01_101, 5'b11_110, 5'b00_011, 3'd7, 2'b11, 1'b0, 1'b0, 1'b0);
        // R1 stride field 10 and 01 give step 1
        run_seq(5'b10_111, 5'b01_000, 5'b10_111, 3'd4, 2'b10, 1'b0, 1'b1, 1'b0);
        run_seq(5'b11_000, 5'b00_111, 5'b01_111, 3'd2, 2'b01, 1'b0, 1'b0, 1'b0);
        // R2 destination in bank 0 forces one element
        run_seq(5'b00_100, 5'b01_001, 5'b10_010, 3'd6, 2'b11, 1'b0, 1'b0, 1'b0);
        // R2 scalar flag forces one element
        run_seq(5'b10_100, 5'b01_001, 5'b10_010, 3'd6, 2'b00, 1'b1, 1'b1, 1'b0);

        // R6 undefined operation
        @(negedge clk);
        start_i = 1'b1; op_undef_i = 1'b1; dst_i = 5'b01_000; len_i = 3'd5; scalar_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0; op_undef_i = 1'b0;
        chk("R6 undef pulse", undef_o, 1);
        chk("R6 no element", elem_vld_o, 0);
        @(negedge clk);
        chk("R6 undef one cycle", undef_o, 0);
        chk("R6 still no element", elem_vld_o, 0);
        chk("R6 no done", done_o, 0);
        repeat (3) @(negedge clk);
        chk("R6 no late done", done_o, 0);

        for (int k = 0; k < 40; k++) begin
            run_seq(5'($urandom_range(0, 31)), 5'($urandom_range(0, 31)),
                    5'($urandom_range(0, 31)), 3'($urandom_range(0, 7)),
                    2'($urandom_range(0, 3)), ($urandom_range(0, 7) == 0),
                    1'($urandom_range(0, 1)), 1'b0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule